// File: doc/BRIEF.md
# Synchronous Serial Port Control Front End

This block is the control side of a synchronous serial port. A simple write-only register bus reaches two control words. The first control word sets the shifter's data-size code, a three-way frame-format choice, a port enable and an 8-bit clock divisor. The second control word holds one interrupt enable per FIFO service channel: channel 0 is receive and channel 1 is transmit.

From the reference clock the block derives the serial bit clock. The bit clock runs only while the port is enabled and the selected format is a legal one. The block decodes the format code into one-hot mode lines for the shifter. It also turns the FIFO service-request flags into two kinds of request. The interrupt requests are masked by the enables. The DMA requests are never masked.

Top module: `sport_ctrl_front`

## Requirements
- R1: After reset, the port is disabled, the data-size output is 0, the format code is 00 (so the SPI mode line is high), the bit clock is low and no interrupt request is raised.
- R2: Writing control word 0 (bus_sel = 0) loads the data-size code from bits 3..0, the format from bits 5..4, the enable from bit 7 and the divisor from bits 15..8, with effect from the cycle after the write. Bit 6 is reserved and has no effect on any output.
- R3: mode_sel is one-hot. Format 00 drives bit 0 (SPI), 01 drives bit 1 (TI synchronous serial) and 10 drives bit 2 (Microwire). Format 11 is reserved and drives no mode bit.
- R4: While the port is enabled with a legal format, bit_clk toggles once every D+1 reference cycles, where D is the divisor (0 to 255). The bit rate is therefore the reference clock divided by 2(D+1).
- R5: While the port is disabled, or the format is 11, bit_clk is low and the divider is held. When counting starts, the first toggle comes D+1 cycles after the enabling write lands.
- R6: A new divisor written while the clock runs is picked up only at a bit clock toggle. The half period in progress keeps its old length. A write that lands on the same edge as a toggle takes effect one toggle later.
- R7: Writing control word 1 (bus_sel = 1) loads the interrupt enables: bit 0 is receive and bit 1 is transmit. irq_req[i] is high exactly when svc_flag[i] and its enable are both 1. Control word 1 does not change any field of control word 0.
- R8: dma_req[i] follows svc_flag[i] whatever the interrupt enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 selects control word 0, 1 selects control word 1 |
| bus_wdata | input | 16 | Write data |
| svc_flag | input | 2 | FIFO service-request flags (0 receive, 1 transmit) |
| bit_clk | output | 1 | Serial bit clock |
| port_en | output | 1 | Port enable as stored |
| size_sel | output | 4 | Data-size code passed to the shifter |
| mode_sel | output | 3 | One-hot frame mode (0 SPI, 1 TI, 2 Microwire) |
| irq_req | output | 2 | Masked interrupt requests |
| dma_req | output | 2 | Unmasked DMA requests |

## Verification
A divisor write and the divider's terminal count can fall on the same reference edge. The register takes the new divisor at the same moment the divider reloads its period. The bench times a write so that it lands exactly on a toggle edge. It then expects one more half period at the old length before the new length appears. A second case lands the write mid-period and expects the current half period to finish at the old length.

// File: rtl/sport_pkg.sv
package sport_pkg;
   // Bit positions inside control word 0; the shifter and bench rely on them.
   localparam int SIZE_LSB = 0;
   localparam int FMT_LSB  = 4;
   localparam int RSVD_BIT = 6;
   localparam int EN_BIT   = 7;
   localparam int DIV_LSB  = 8;

   // Frame format codes.
   localparam logic [1:0] FMT_SPI  = 2'b00;
   localparam logic [1:0] FMT_TI   = 2'b01;
   localparam logic [1:0] FMT_MW   = 2'b10;
   localparam logic [1:0] FMT_RSVD = 2'b11;

   localparam int NUM_MODES = 3;
endpackage

// File: rtl/sport_ctl_regs.sv
module sport_ctl_regs
   import sport_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SIZE_W = 4,
   parameter int NCH    = 2,
   localparam int DIV_W = DATA_W - DIV_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DIV_W-1:0]  div,
   output logic              en,
   output logic [1:0]        fmt,
   output logic [SIZE_W-1:0] size,
   output logic [NCH-1:0]    ien
);
   // Reserved bit and unused gap bits are accepted and dropped.
   logic unused_rsvd;
   assign unused_rsvd = wdata[RSVD_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div  <= '0;
         en   <= 1'b0;
         fmt  <= FMT_SPI;
         size <= '0;
         ien  <= '0;
      end else if (wr) begin
         if (!sel) begin
            div  <= wdata[DATA_W-1:DIV_LSB];
            en   <= wdata[EN_BIT];
            fmt  <= wdata[FMT_LSB+1:FMT_LSB];
            size <= wdata[SIZE_LSB+SIZE_W-1:SIZE_LSB];
         end else begin
            ien  <= wdata[NCH-1:0];
         end
      end
   end
endmodule

// File: rtl/sport_bitclk_gen.sv
module sport_bitclk_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_in,
   output logic             bit_clk
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] act_div;
   logic             run_q;
   logic [DIV_W-1:0] eff_div;

   // First counting cycle uses the live divisor; afterwards the latched one.
   assign eff_div = run_q ? act_div : div_in;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt     <= '0;
         bit_clk <= 1'b0;
         run_q   <= 1'b0;
         act_div <= div_in;
      end else begin
         run_q <= 1'b1;
         if (!run_q) act_div <= div_in;
         if (cnt == eff_div) begin
            cnt     <= '0;
            bit_clk <= ~bit_clk;
            act_div <= div_in;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sport_req_gate.sv
module sport_req_gate #(
   parameter int NCH = 2
) (
   input  logic [NCH-1:0] svc,
   input  logic [NCH-1:0] ien,
   output logic [NCH-1:0] irq,
   output logic [NCH-1:0] dma
);
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign irq[i] = svc[i] & ien[i];
      assign dma[i] = svc[i];
   end
endmodule

// File: rtl/sport_mode_dec.sv
module sport_mode_dec
   import sport_pkg::*;
(
   input  logic [1:0]           fmt,
   output logic [NUM_MODES-1:0] mode
);
   for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
      assign mode[m] = (fmt == 2'(m));
   end
endmodule

// File: rtl/sport_ctrl_front.sv
module sport_ctrl_front
   import sport_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SIZE_W = 4,
   parameter int NCH    = 2,
   localparam int DIV_W = DATA_W - DIV_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_sel,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [NCH-1:0]    svc_flag,
   output logic              bit_clk,
   output logic              port_en,
   output logic [SIZE_W-1:0] size_sel,
   output logic [NUM_MODES-1:0] mode_sel,
   output logic [NCH-1:0]    irq_req,
   output logic [NCH-1:0]    dma_req
);
   if (DATA_W < DIV_LSB + 1) begin : g_bad_data_w
      $error("DATA_W must leave room for a divisor above bit %0d", DIV_LSB);
   end
   if (SIZE_W < 1 || SIZE_W > FMT_LSB) begin : g_bad_size_w
      $error("SIZE_W must be 1..%0d", FMT_LSB);
   end
   if (NCH < 1 || NCH > DATA_W) begin : g_bad_nch
      $error("NCH must be 1..DATA_W");
   end

   logic [DIV_W-1:0] div;
   logic [1:0]       fmt;
   logic [NCH-1:0]   ien;
   logic             run;

   sport_ctl_regs #(.DATA_W(DATA_W), .SIZE_W(SIZE_W), .NCH(NCH)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(bus_sel), .wdata(bus_wdata),
      .div(div), .en(port_en), .fmt(fmt), .size(size_sel), .ien(ien)
   );

   assign run = port_en && (fmt != FMT_RSVD);

   sport_bitclk_gen #(.DIV_W(DIV_W)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(run), .div_in(div), .bit_clk(bit_clk)
   );

   sport_mode_dec u_mode (.fmt(fmt), .mode(mode_sel));

   sport_req_gate #(.NCH(NCH)) u_req (
      .svc(svc_flag), .ien(ien), .irq(irq_req), .dma(dma_req)
   );
endmodule

// File: rtl/sport_ctrl_front_chk.sv
module sport_ctrl_front_chk
   import sport_pkg::*;
#(
   parameter int SIZE_W = 4,
   parameter int NCH    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr,
   input logic                 bus_sel,
   input logic [SIZE_W-1:0]    wd_size,
   input logic [1:0]           wd_fmt,
   input logic [NCH-1:0]       wd_ien,
   input logic [NCH-1:0]       svc_flag,
   input logic [NCH-1:0]       irq_req,
   input logic [NCH-1:0]       dma_req,
   input logic                 port_en,
   input logic                 bit_clk,
   input logic [NUM_MODES-1:0] mode_sel,
   input logic [SIZE_W-1:0]    size_sel
);
   a_r2_size_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_sel) |=> (size_sel == $past(wd_size)));

   a_r3_modes_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mode_sel));

   a_r3_reserved_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_sel && wd_fmt == FMT_RSVD) |=> (mode_sel == '0));

   a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_en && $past(!port_en)) |-> !bit_clk);

   a_r7_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel) |=> ((irq_req & ~$past(wd_ien)) == '0));

   a_r8_dma_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel) |=> (dma_req == svc_flag));
endmodule

bind sport_ctrl_front sport_ctrl_front_chk #(.SIZE_W(SIZE_W), .NCH(NCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
   .wd_size(bus_wdata[SIZE_W-1:0]), .wd_fmt(bus_wdata[5:4]),
   .wd_ien(bus_wdata[NCH-1:0]), .svc_flag(svc_flag), .irq_req(irq_req),
   .dma_req(dma_req), .port_en(port_en), .bit_clk(bit_clk),
   .mode_sel(mode_sel), .size_sel(size_sel)
);

// File: tb/sport_ctrl_front_tb.sv
module sport_ctrl_front_tb;
   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_sel = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [1:0]  svc_flag = '0;
   logic        bit_clk, port_en;
   logic [3:0]  size_sel;
   logic [2:0]  mode_sel;
   logic [1:0]  irq_req, dma_req;

   sport_ctrl_front u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .svc_flag(svc_flag), .bit_clk(bit_clk),
      .port_en(port_en), .size_sel(size_sel), .mode_sel(mode_sel),
      .irq_req(irq_req), .dma_req(dma_req)
   );

   always #(CLK_NS/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] w0(logic [7:0] d, logic en, logic [1:0] f, logic [3:0] sz);
      return {d, en, 1'b0, f, sz};
   endfunction

   task automatic wr(logic s, logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic wait_tog(output int t);
      logic p;
      int k;
      p = bit_clk; k = 0;
      do begin
         @(posedge clk); #1; k++;
      end while (bit_clk == p && k < 2000);
      if (bit_clk == p) chk("R4 toggle timeout", 0, 1);
      t = cyc;
   endtask

   initial begin
      #(CLK_NS * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int t0, t1, t2, t3, t4, t5;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      chk("R1 bit_clk", bit_clk, 0);
      chk("R1 port_en", port_en, 0);
      chk("R1 size", size_sel, 0);
      chk("R1 mode", mode_sel, 1);
      chk("R1 irq", irq_req, 0);

      // R3 format decode, port disabled
      for (int f = 0; f < 4; f++) begin
         wr(1'b0, w0(8'd0, 1'b0, 2'(f), 4'd0));
         chk("R3 mode", mode_sel, (f == 3) ? 0 : (1 << f));
      end

      // R2 size sweep, reserved bit toggled alternately
      for (int sz = 0; sz < 16; sz++) begin
         wr(1'b0, w0(8'd9, 1'b0, 2'b10, 4'(sz)) | ((sz % 2 == 1) ? 16'h0040 : 16'h0000));
         chk("R2 size", size_sel, sz);
         chk("R2 enable w/ reserved bit", port_en, 0);
         chk("R2 mode w/ reserved bit", mode_sel, 4);
      end

      // R5 reserved format with enable: clock idle
      wr(1'b0, w0(8'd0, 1'b1, 2'b11, 4'd0));
      for (int k = 0; k < 20; k++) begin
         @(posedge clk); #1;
         chk("R5 reserved fmt idle", bit_clk, 0);
      end

      // R4/R5 divisor sweep
      for (int d = 0; d < 256; d++) begin
         wr(1'b0, w0(8'(d), 1'b0, 2'b00, 4'd5));
         @(posedge clk); #1;
         chk("R5 disabled low", bit_clk, 0);
         wr(1'b0, w0(8'(d), 1'b1, 2'b00, 4'd5));
         t0 = cyc;
         wait_tog(t1);
         chk("R5 first toggle", t1 - t0, d + 1);
         wait_tog(t2);
         chk("R4 half period", t2 - t1, d + 1);
      end
      chk("R2 enable", port_en, 1);

      // R6 divisor change mid half period
      wr(1'b0, w0(8'd5, 1'b0, 2'b01, 4'd0));
      @(posedge clk); #1;
      wr(1'b0, w0(8'd5, 1'b1, 2'b01, 4'd0));
      wait_tog(t0);
      repeat (2) @(posedge clk);
      wr(1'b0, w0(8'd2, 1'b1, 2'b01, 4'd0));
      wait_tog(t1);
      chk("R6 old length kept", t1 - t0, 6);
      wait_tog(t2);
      chk("R6 new length", t2 - t1, 3);

      // R6 write landing on the toggle edge
      repeat (2) @(posedge clk);
      wr(1'b0, w0(8'd1, 1'b1, 2'b01, 4'd0));
      t3 = cyc;
      chk("R6 write on toggle edge", t3 - t2, 3);
      chk("R6 toggled on that edge", bit_clk, 0);
      wait_tog(t4);
      chk("R6 one more old half", t4 - t3, 3);
      wait_tog(t5);
      chk("R6 new after next toggle", t5 - t4, 2);

      // R7 control word 1 leaves word 0 alone
      wr(1'b1, 16'h0003);
      chk("R7 size kept", size_sel, 0);
      chk("R7 mode kept", mode_sel, 2);
      chk("R7 enable kept", port_en, 1);
      wait_tog(t0);
      wait_tog(t1);
      chk("R7 divisor kept", t1 - t0, 2);

      // R7/R8 enable x flag sweep
      for (int ie = 0; ie < 4; ie++) begin
         wr(1'b1, 16'(ie));
         for (int f = 0; f < 4; f++) begin
            svc_flag = 2'(f);
            #1;
            chk("R7 irq", irq_req, f & ie);
            chk("R8 dma", dma_req, f);
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule